// File: doc/BRIEF.md
# Bit-Serial Feistel Encryption Core

This block encrypts one 32-bit block with a lightweight Feistel cipher whose state is two 16-bit words. Each round is computed one bit per clock, least significant bit first. A round therefore takes 16 cycles, and a full encryption of 32 rounds takes 512 cycles. The round keys are not stored here. A separate key-schedule block supplies them as a serial bit stream, one bit in each cycle that the core asks for one.

The round update is new_upper = lower ^ (rotl1(upper) & rotl8(upper)) ^ rotl2(upper) ^ key, and new_lower = upper. The upper word sits in a live shift register. Each bit shifted out of it passes into a second 16-bit FIFO, which holds the remaining old lower bits followed by the bits of the old upper word. Every rotated operand comes from a single fixed position, taken from either the live register or the FIFO depending on the bit index. No cycle is spent on operand selection.

A start strobe loads the plaintext and begins an encryption. When the last bit of the last round has been written, a one-cycle done pulse marks the ciphertext as valid. The ciphertext then stays unchanged until the next start.

Top module: `serial_feistel_core`

## Requirements
- R1: A start sampled high while the core is idle loads plain_in, with bits 31:16 as the upper word and bits 15:0 as the lower word. key_req is high in the next cycle, and in that cycle cipher_out equals the loaded plaintext.
- R2: The result is 32 rounds of new_upper = lower ^ (rotl1(upper) & rotl8(upper)) ^ rotl2(upper) ^ k[r] and new_lower = upper. cipher_out is {upper, lower}.
- R3: key_req is high for exactly 512 consecutive cycles per encryption. In the cycle that is the n-th one with key_req high (n counted from 0), key_bit must carry bit n%16 of round key n/16. key_req is low whenever done is high.
- R4: done is high for exactly one cycle. It rises 512 cycles after the clock edge that accepted the start.
- R5: With round keys expanded from key words 1918 1110 0908 0100 (hex, most significant word first) and plaintext 65656877, the ciphertext is c69be9bb.
- R6: While the core is idle and start is low, cipher_out holds its value and key_req stays low.
- R7: A start sampled while key_req is high has no effect. The bit and round sequencing continues, and the result and the done timing are those of the encryption already running.
- R8: A synchronous reset clears done, key_req and the counters, which aborts any encryption in progress. No done pulse follows an aborted run.
- R9: A start sampled in the same cycle as done begins a new encryption at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an encryption; used only when idle |
| plain_in | input | 32 | Plaintext, upper word in bits 31:16 |
| key_bit | input | 1 | Current round-key bit, LSB first |
| key_req | output | 1 | Core consumes key_bit in this cycle |
| cipher_out | output | 32 | Ciphertext, valid from done onward |
| done | output | 1 | One-cycle pulse when encryption ends |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a run, at the boundary between a round and the next, or exactly in the done cycle. In those cases the counters must neither restart nor lose a cycle. The stimulus pokes start at random bit positions inside busy runs, with a different plaintext on the input. It also chains a second encryption onto the done cycle and resets in the middle of a run. Every result is then compared against a reference computed in the bench from random keys and blocks.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    localparam int WORD_W_DEF  = 16;
    localparam int ROUND_N_DEF = 32;
    localparam int ROT_A_DEF   = 1;
    localparam int ROT_B_DEF   = 8;
    localparam int ROT_C_DEF   = 2;
endpackage

// File: rtl/lwc_sequencer.sv
module lwc_sequencer #(
    parameter int W      = 16,
    parameter int ROUNDS = 32,
    localparam int BW    = $clog2(W),
    localparam int RW    = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          load,
    output logic [BW-1:0] bit_idx,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [BW-1:0] bit_cnt;
        logic [RW-1:0] rnd_cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        load       = !seq_q.busy && start;
        if (load) begin
            seq_d.busy    = 1'b1;
            seq_d.bit_cnt = '0;
            seq_d.rnd_cnt = '0;
        end else if (seq_q.busy) begin
            if (seq_q.bit_cnt == BW'(W - 1)) begin
                seq_d.bit_cnt = '0;
                if (seq_q.rnd_cnt == RW'(ROUNDS - 1)) begin
                    seq_d.busy    = 1'b0;
                    seq_d.done    = 1'b1;
                    seq_d.rnd_cnt = '0;
                end else begin
                    seq_d.rnd_cnt = seq_q.rnd_cnt + 1'b1;
                end
            end else begin
                seq_d.bit_cnt = seq_q.bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = seq_q.busy;
    assign bit_idx = seq_q.bit_cnt;
    assign done    = seq_q.done;
endmodule

// File: rtl/lwc_tap_pick.sv
module lwc_tap_pick #(
    parameter int W   = 16,
    parameter int ROT = 1,
    localparam int BW  = $clog2(W),
    localparam int POS = W - ROT
) (
    input  logic [W-1:0]  live_word,
    input  logic [W-1:0]  fifo_word,
    input  logic [BW-1:0] bit_idx,
    output logic          tap
);
    // Old bit (i-ROT) mod W sits at index W-ROT: still in the live word
    // before wrap-around is passed, already moved into the FIFO after.
    assign tap = (bit_idx < BW'(ROT)) ? live_word[POS] : fifo_word[POS];
endmodule

// File: rtl/lwc_round_bit.sv
module lwc_round_bit (
    input  logic lower_bit,
    input  logic and_a,
    input  logic and_b,
    input  logic xor_c,
    input  logic key_bit,
    output logic new_bit
);
    assign new_bit = lower_bit ^ (and_a & and_b) ^ xor_c ^ key_bit;
endmodule

// File: rtl/serial_feistel_core.sv
module serial_feistel_core #(
    parameter int WORD_W  = lwc_pkg::WORD_W_DEF,
    parameter int ROUND_N = lwc_pkg::ROUND_N_DEF,
    parameter int ROT_A   = lwc_pkg::ROT_A_DEF,
    parameter int ROT_B   = lwc_pkg::ROT_B_DEF,
    parameter int ROT_C   = lwc_pkg::ROT_C_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [2*WORD_W-1:0]   plain_in,
    input  logic                  key_bit,
    output logic                  key_req,
    output logic [2*WORD_W-1:0]   cipher_out,
    output logic                  done
);
    localparam int BW = $clog2(WORD_W);
    localparam int ROT_LIST [3] = '{ROT_A, ROT_B, ROT_C};

    typedef struct packed {
        logic [WORD_W-1:0] live;
        logic [WORD_W-1:0] fifo;
    } store_t;

    store_t            st_d, st_q;
    logic              busy, load;
    logic [BW-1:0]     bit_idx;
    logic [2:0]        taps;
    logic              new_bit;

    lwc_sequencer #(.W(WORD_W), .ROUNDS(ROUND_N)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .load    (load),
        .bit_idx (bit_idx),
        .done    (done)
    );

    for (genvar g = 0; g < 3; g++) begin : g_tap
        lwc_tap_pick #(.W(WORD_W), .ROT(ROT_LIST[g])) i_tap (
            .live_word (st_q.live),
            .fifo_word (st_q.fifo),
            .bit_idx   (bit_idx),
            .tap       (taps[g])
        );
    end

    lwc_round_bit i_bit (
        .lower_bit (st_q.fifo[0]),
        .and_a     (taps[0]),
        .and_b     (taps[1]),
        .xor_c     (taps[2]),
        .key_bit   (key_bit),
        .new_bit   (new_bit)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.live = plain_in[2*WORD_W-1:WORD_W];
            st_d.fifo = plain_in[WORD_W-1:0];
        end else if (busy) begin
            st_d.live = {new_bit, st_q.live[WORD_W-1:1]};
            st_d.fifo = {st_q.live[0], st_q.fifo[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_req    = busy;
    assign cipher_out = {st_q.live, st_q.fifo};
endmodule

// File: rtl/lwc_core_checker.sv
module lwc_core_checker #(
    parameter int W      = 16,
    parameter int ROUNDS = 32,
    localparam int BW    = $clog2(W),
    localparam int CW    = $clog2(W * ROUNDS) + 2
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [2*W-1:0] plain_in,
    input logic           key_req,
    input logic           done,
    input logic [2*W-1:0] cipher_out,
    input logic [BW-1:0]  bit_idx
);
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (!key_req && start) begin
            run_cnt <= '0;
        end else if (key_req) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        (!key_req && start) |=> (key_req && cipher_out == $past(plain_in)));

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !key_req);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_latency_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == CW'(W * ROUNDS)));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!key_req && !start) |=> ($stable(cipher_out) && !key_req));

    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        (key_req && start && bit_idx != BW'(W - 1))
            |=> (key_req && bit_idx == BW'($past(bit_idx) + 1'b1)));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!done && !key_req));
endmodule

bind serial_feistel_core lwc_core_checker #(.W(WORD_W), .ROUNDS(ROUND_N)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .plain_in   (plain_in),
    .key_req    (key_req),
    .done       (done),
    .cipher_out (cipher_out),
    .bit_idx    (bit_idx)
);

// File: tb/test_serial_feistel_core.sv
`timescale 1ns/1ps
module test_serial_feistel_core;
    localparam int NBITS = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        key_bit = 1'b0;
    logic [31:0] plain_in = '0;
    logic        key_req, done;
    logic [31:0] cipher_out;

    int checks = 0;
    int fails  = 0;
    logic [15:0] rk [0:31];

    always #2.5 clk = ~clk;

    serial_feistel_core i_serial_feistel_core (
        .clk(clk), .rst(rst), .start(start), .plain_in(plain_in),
        .key_bit(key_bit), .key_req(key_req), .cipher_out(cipher_out), .done(done)
    );

    function automatic logic [15:0] rotl(input logic [15:0] v, input int s);
        return (v << s) | (v >> (16 - s));
    endfunction

    function automatic logic [15:0] rotr(input logic [15:0] v, input int s);
        return (v >> s) | (v << (16 - s));
    endfunction

    task automatic expand(input logic [63:0] key);
        logic [30:0] zseq = 31'b1111101000100101011000011100110;
        for (int i = 0; i < 4; i++) rk[i] = key[16*i +: 16];
        for (int i = 4; i < 32; i++) begin
            logic [15:0] t;
            t = rotr(rk[i-1], 3) ^ rk[i-3];
            t = t ^ rotr(t, 1);
            rk[i] = rk[i-4] ^ t ^ 16'hFFFC ^ {15'd0, zseq[30 - ((i-4) % 31)]};
        end
    endtask

    function automatic logic [31:0] ref_enc(input logic [31:0] pt);
        logic [15:0] x = pt[31:16];
        logic [15:0] y = pt[15:0];
        for (int r = 0; r < 32; r++) begin
            logic [15:0] t = x;
            x = y ^ (rotl(x, 1) & rotl(x, 8)) ^ rotl(x, 2) ^ rk[r];
            y = t;
        end
        return {x, y};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge with the core idle; returns at the falling edge where done is seen.
    task automatic run_enc(input logic [31:0] pt, input logic [63:0] key, input int poke,
                           output logic [31:0] ct, output int nreq);
        int n = 0;
        expand(key);
        start = 1'b1;
        plain_in = pt;
        @(negedge clk);
        start = 1'b0;
        chk(key_req == 1'b1, "R1 key_req after start", {31'd0, key_req}, 32'd1);
        chk(cipher_out == pt, "R1 loaded block", cipher_out, pt);
        while (!done && n < 2000) begin
            if (key_req) begin
                key_bit = rk[n / 16][n % 16];
                n++;
            end
            if (poke >= 0 && n == poke) begin
                start = 1'b1;            // R7: strobe during busy
                plain_in = ~pt;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b1, "R4 done reached", {31'd0, done}, 32'd1);
        chk(key_req == 1'b0, "R3 key_req low at done", {31'd0, key_req}, 32'd0);
        ct = cipher_out;
        nreq = n;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] ct, exp, held;
        int nreq;
        bit seen;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        chk(done == 1'b0 && key_req == 1'b0, "R8 reset state", {30'd0, done, key_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(key_req == 1'b0, "R6 idle after reset", {31'd0, key_req}, 32'd0);

        // R5 known vector
        run_enc(32'h6565_6877, 64'h1918_1110_0908_0100, -1, ct, nreq);
        chk(ct == 32'hc69b_e9bb, "R5 known vector", ct, 32'hc69b_e9bb);
        chk(ct == ref_enc(32'h6565_6877), "R2 reference", ct, ref_enc(32'h6565_6877));
        chk(nreq == NBITS, "R4 latency", nreq, NBITS);
        held = cipher_out;
        @(negedge clk);
        chk(done == 1'b0, "R4 single pulse", {31'd0, done}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            plain_in = $urandom;
            @(negedge clk);
            chk(cipher_out == held && !key_req, "R6 hold while idle", cipher_out, held);
        end

        // R2/R3/R7 random runs, some with a start poked mid-run
        for (int t = 0; t < 8; t++) begin
            logic [31:0] pt = $urandom;
            logic [63:0] key = {$urandom, $urandom};
            int poke = (t % 2 == 1) ? int'($urandom_range(1, 511)) : -1;
            if (t == 3) poke = 16;       // round boundary
            if (t == 5) poke = 511;      // last bit
            run_enc(pt, key, poke, ct, nreq);
            exp = ref_enc(pt);
            chk(ct == exp, (poke >= 0) ? "R7 busy start ignored" : "R2 random block", ct, exp);
            chk(nreq == NBITS, "R3 key bit count", nreq, NBITS);
            @(negedge clk);
        end

        // R9 back-to-back: second start in the done cycle
        run_enc(32'h0123_4567, 64'h0f1e_2d3c_4b5a_6978, -1, ct, nreq);
        run_enc(32'hdead_beef, 64'h1357_9bdf_0246_8ace, -1, ct, nreq);
        exp = ref_enc(32'hdead_beef);
        chk(ct == exp, "R9 chained start", ct, exp);
        @(negedge clk);

        // R8 reset mid-run
        start = 1'b1;
        plain_in = $urandom;
        @(negedge clk);
        start = 1'b0;
        repeat (40) begin
            key_bit = 1'($urandom);
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(key_req == 1'b0 && done == 1'b0, "R8 abort clears", {30'd0, done, key_req}, 32'd0);
        seen = 1'b0;
        repeat (600) begin
            @(negedge clk);
            if (done || key_req) seen = 1'b1;
        end
        chk(!seen, "R8 no done after abort", {31'd0, seen}, 32'd0);

        run_enc(32'h6565_6877, 64'h1918_1110_0908_0100, -1, ct, nreq);
        chk(ct == 32'hc69b_e9bb, "R5 vector after reset", ct, 32'hc69b_e9bb);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule